// File: doc/BRIEF.md
# Single-Frame Lookahead Receive Buffer

This block sits between a receiver front end and a processor bus. The front end hands over the bytes of one frame, one byte per cycle, and flags the last byte. The buffer stores the bytes and raises an interrupt once the frame is complete. Software then drains the bytes over a strobed parallel bus. Only one frame is held at a time. The first byte of a new frame rewinds both pointers, so any bytes of the previous frame that were not read are discarded.

To keep read latency low, the block always fetches the next stored byte into a holding register ahead of the bus read. As a result, the empty output goes high while the final byte is still sitting in the holding register. Software therefore reads until empty is seen and then issues exactly one more read. A second bus space holds a status byte, which can be read, and a command byte, which can be written, to clear the interrupt and the sticky overflow flag.

Top module: `rxf_frame_buf`

## Requirements
- R1: After reset, rx_empty is 1, rx_irq is 0 and bus_rdata is 0x00.
- R2: A FIFO read is a one-cycle strobe with bus_strb=1, bus_rd=1 and bus_reg=0. bus_rdata shows the returned byte from the next cycle on, and successive reads return the frame's bytes in arrival order.
- R3: rx_empty is 1 whenever no stored byte remains beyond the one in the holding register. The read issued after rx_empty rises returns the frame's last byte. This includes a frame of a single byte.
- R4: A FIFO read while the holding register is empty returns 0x00 and does not move the read pointer.
- R5: A byte with in_valid=1 that arrives after a completed frame, or as the first byte after reset, starts a new frame. It rewinds the read and write pointers, and later reads return only the new frame's bytes.
- R6: rx_irq rises in the cycle after a byte with in_valid=1 and in_eof=1 is accepted.
- R7: The first FIFO read clears rx_irq.
- R8: A register write (bus_strb=1, bus_rd=0, bus_reg=1) with bus_wdata bit 0 set clears rx_irq. A register write with bit 0 clear leaves rx_irq unchanged.
- R9: A frame holds at most DEPTH (64) bytes. Later bytes of that frame are dropped, the overflow flag is set, and the first 64 bytes read back intact.
- R10: The overflow flag is sticky. It survives new frames and clears only on a register write with bus_wdata bit 1 set.
- R11: A register read (bus_strb=1, bus_rd=1, bus_reg=1) returns a status byte on bus_rdata the next cycle. Bit 0 is the interrupt, bit 1 is overflow, bit 2 is empty, and all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Received byte valid |
| in_byte | input | 8 | Received byte |
| in_eof | input | 1 | Marks the valid byte as the last of its frame |
| bus_strb | input | 1 | One-cycle bus access strobe, active high |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_reg | input | 1 | 1 = status/command register, 0 = FIFO |
| bus_wdata | input | 8 | Command byte for register writes |
| bus_rdata | output | 8 | Registered read data |
| rx_empty | output | 1 | No byte left beyond the holding register |
| rx_irq | output | 1 | End-of-frame interrupt |

## Verification
The bench drains frames of several lengths and checks that rx_empty goes high one read before the data runs out. A design that flagged empty only after the last byte would break this check, and so would one that lost the held byte. A one-byte frame tests the case where the holding register carries the whole frame.

A second frame arrives while the first is half read, which exposes any failure to rewind the pointers: stale bytes would come back. A 70-byte frame shows whether extra bytes wrap over the first ones or fail to set the sticky flag. Reads made after the buffer is drained must return zero without disturbing the next frame. Interrupt clears through a read and through a command write are checked separately.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_POP    = 2'd1,
    OP_REG_RD = 2'd2,
    OP_REG_WR = 2'd3
  } bus_op_e;

  localparam int ST_IRQ   = 0;
  localparam int ST_OVF   = 1;
  localparam int ST_EMPTY = 2;

  localparam int CMD_CLR_IRQ = 0;
  localparam int CMD_CLR_OVF = 1;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              in_eof,
  input  logic              ovf_clr,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_byte,
  output logic [CNT_W-1:0]  wr_count,
  output logic              frame_start,
  output logic              frame_end,
  output logic              ovf
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              open_q, open_d;
  logic [CNT_W-1:0]  wcnt_q, wcnt_d, base;
  logic              ovf_q, ovf_d;
  logic              room, wr_en;

  always_comb begin
    frame_start = in_valid & ~open_q;
    frame_end   = in_valid & in_eof;
    base        = frame_start ? '0 : wcnt_q;
    room        = base < FULL;
    wr_en       = in_valid & room;
    wcnt_d      = wr_en ? base + 1'b1 : base;
    if (frame_end)     open_d = 1'b0;
    else if (in_valid) open_d = 1'b1;
    else               open_d = open_q;
    ovf_d = (in_valid & ~room) | (ovf_q & ~ovf_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      wcnt_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      open_q <= open_d;
      wcnt_q <= wcnt_d;
      ovf_q  <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[base[PTR_W-1:0]] <= in_byte;
  end

  assign rd_byte  = mem[rd_addr];
  assign wr_count = wcnt_q;
  assign ovf      = ovf_q;

  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && open_q && wcnt_q == FULL) |=> (wcnt_q == FULL && ovf_q)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q); // R10
  AST_START_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (wcnt_q == CNT_W'(1))); // R5
endmodule

// File: rtl/rxf_lookahead.sv
module rxf_lookahead #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              pop,
  input  logic [CNT_W-1:0]  wr_count,
  input  logic [DATA_W-1:0] rd_byte,
  output logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] hold_byte,
  output logic              hold_vld,
  output logic              empty
);
  logic [CNT_W-1:0]  rptr_q, rptr_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              hvld_q, hvld_d;
  logic              avail;

  always_comb begin
    avail  = rptr_q < wr_count;
    rptr_d = rptr_q;
    hold_d = hold_q;
    hvld_d = hvld_q;
    if (restart) begin
      rptr_d = '0;
      hvld_d = 1'b0;
    end else if (pop && !hvld_q) begin
      rptr_d = rptr_q;
    end else if (!hvld_q || pop) begin
      if (avail) begin
        hold_d = rd_byte;
        hvld_d = 1'b1;
        rptr_d = rptr_q + 1'b1;
      end else begin
        hvld_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      hold_q <= '0;
      hvld_q <= 1'b0;
    end else begin
      rptr_q <= rptr_d;
      hold_q <= hold_d;
      hvld_q <= hvld_d;
    end
  end

  assign rd_addr   = rptr_q[PTR_W-1:0];
  assign hold_byte = hold_q;
  assign hold_vld  = hvld_q;
  assign empty     = ~avail;

  AST_PREFETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!hvld_q && !empty && !restart && !pop) |=> hvld_q); // R3
  AST_RESTART_DROPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !hvld_q); // R5
  AST_IDLE_READ_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !hvld_q && !restart) |=> $stable(rptr_q)); // R4
endmodule

// File: rtl/rxf_frame_buf.sv
module rxf_frame_buf
  import rxf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              in_eof,
  input  logic              bus_strb,
  input  logic              bus_rd,
  input  logic              bus_reg,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rx_empty,
  output logic              rx_irq
);
  bus_op_e           op;
  logic              pop, reg_rd, reg_wr, ovf_clr;
  logic [PTR_W-1:0]  rd_addr;
  logic [DATA_W-1:0] rd_byte, hold_byte, status;
  logic [CNT_W-1:0]  wr_count;
  logic              frame_start, frame_end, ovf, hold_vld, empty;
  logic              irq_q, irq_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_comb begin
    if (!bus_strb)    op = OP_IDLE;
    else if (!bus_reg) op = bus_rd ? OP_POP : OP_IDLE;
    else               op = bus_rd ? OP_REG_RD : OP_REG_WR;
    pop     = (op == OP_POP);
    reg_rd  = (op == OP_REG_RD);
    reg_wr  = (op == OP_REG_WR);
    ovf_clr = reg_wr & bus_wdata[CMD_CLR_OVF];
  end

  rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_byte(in_byte), .in_eof(in_eof),
    .ovf_clr(ovf_clr), .rd_addr(rd_addr), .rd_byte(rd_byte),
    .wr_count(wr_count), .frame_start(frame_start),
    .frame_end(frame_end), .ovf(ovf)
  );

  rxf_lookahead #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_look (
    .clk(clk), .rst_n(rst_n),
    .restart(frame_start), .pop(pop),
    .wr_count(wr_count), .rd_byte(rd_byte), .rd_addr(rd_addr),
    .hold_byte(hold_byte), .hold_vld(hold_vld), .empty(empty)
  );

  always_comb begin
    status           = '0;
    status[ST_IRQ]   = irq_q;
    status[ST_OVF]   = ovf;
    status[ST_EMPTY] = empty;

    if (frame_end)                                   irq_d = 1'b1;
    else if (pop || (reg_wr && bus_wdata[CMD_CLR_IRQ])) irq_d = 1'b0;
    else                                             irq_d = irq_q;

    if (pop)         rdata_d = hold_vld ? hold_byte : '0;
    else if (reg_rd) rdata_d = status;
    else             rdata_d = rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      irq_q   <= irq_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign rx_empty  = empty;
  assign rx_irq    = irq_q;

  AST_IRQ_ON_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> rx_irq); // R6
  AST_IRQ_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !frame_end) |=> !rx_irq); // R7
  AST_IRQ_CMD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !bus_wdata[CMD_CLR_IRQ] && irq_q) |=> rx_irq); // R8
  AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !hold_vld) |=> (bus_rdata == '0)); // R4
endmodule

// File: tb/test_rxf_frame_buf.sv
module test_rxf_frame_buf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_eof = 1'b0;
  logic [7:0] in_byte = '0;
  logic       bus_strb = 1'b0, bus_rd = 1'b0, bus_reg = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rx_empty, rx_irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       rd_seen = 1'b0;

  always #2 clk = ~clk;

  rxf_frame_buf i_rxf_frame_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_eof(in_eof), .bus_strb(bus_strb), .bus_rd(bus_rd), .bus_reg(bus_reg),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_empty(rx_empty),
    .rx_irq(rx_irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares each read result with the scoreboard head
  always @(posedge clk) rd_seen <= bus_strb & bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected read", bus_rdata, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(bus_rdata == e, t, bus_rdata, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit eof);
    in_valid = 1'b1; in_byte = b; in_eof = eof;
    @(negedge clk);
    in_valid = 1'b0; in_eof = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] base, input int n);
    for (int i = 0; i < n; i++) send_byte(base + 8'(i), i == n - 1);
  endtask

  task automatic rd_fifo(input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_strb = 1'b1; bus_rd = 1'b1; bus_reg = 1'b0;
    @(negedge clk);
    bus_strb = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_strb = 1'b1; bus_rd = 1'b1; bus_reg = 1'b1;
    @(negedge clk);
    bus_strb = 1'b0; bus_rd = 1'b0; bus_reg = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] v);
    bus_strb = 1'b1; bus_rd = 1'b0; bus_reg = 1'b1; bus_wdata = v;
    @(negedge clk);
    bus_strb = 1'b0; bus_reg = 1'b0; bus_wdata = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk(rx_empty == 1'b1, "R1 empty after reset", rx_empty, 1);
    chk(rx_irq == 1'b0, "R1 irq after reset", rx_irq, 0);
    chk(bus_rdata == 8'h00, "R1 rdata after reset", bus_rdata, 0);

    // five-byte frame
    send_frame(8'h10, 5);
    chk(rx_irq == 1'b1, "R6 irq after eof", rx_irq, 1);
    idle(2);
    chk(rx_empty == 1'b0, "R3 not empty with bytes stored", rx_empty, 0);
    rd_reg(8'h01, "R11 status irq only");
    rd_fifo(8'h10, "R2 byte0");
    chk(rx_irq == 1'b0, "R7 irq cleared by read", rx_irq, 0);
    rd_fifo(8'h11, "R2 byte1");
    rd_fifo(8'h12, "R2 byte2");
    chk(rx_empty == 1'b0, "R3 empty early", rx_empty, 0);
    rd_fifo(8'h13, "R2 byte3");
    chk(rx_empty == 1'b1, "R3 empty with last byte held", rx_empty, 1);
    rd_fifo(8'h14, "R3 extra read gets last byte");
    rd_fifo(8'h00, "R4 read with nothing held");
    rd_fifo(8'h00, "R4 second read with nothing held");

    // partial read then a new frame
    send_frame(8'h40, 4);
    idle(2);
    rd_fifo(8'h40, "R2 frame B byte0");
    rd_fifo(8'h41, "R2 frame B byte1");
    send_frame(8'h80, 3);
    idle(2);
    chk(rx_irq == 1'b1, "R6 irq for frame C", rx_irq, 1);
    wr_reg(8'h02);
    chk(rx_irq == 1'b1, "R8 write without bit0 keeps irq", rx_irq, 1);
    wr_reg(8'h01);
    chk(rx_irq == 1'b0, "R8 write bit0 clears irq", rx_irq, 0);
    rd_fifo(8'h80, "R5 new frame byte0");
    rd_fifo(8'h81, "R5 new frame byte1");
    chk(rx_empty == 1'b1, "R3 empty before last of frame C", rx_empty, 1);
    rd_fifo(8'h82, "R5 new frame byte2");
    rd_fifo(8'h00, "R4 drained frame C");

    // overflow frame of 70 bytes
    send_frame(8'h00, 70);
    idle(2);
    rd_reg(8'h03, "R9 status overflow and irq");
    for (int i = 0; i < 64; i++) begin
      if (i == 63) chk(rx_empty == 1'b1, "R9 empty before byte 63", rx_empty, 1);
      rd_fifo(8'(i), "R9 overflow frame byte");
    end
    rd_fifo(8'h00, "R9 dropped bytes not stored");

    // overflow survives a new frame
    send_frame(8'hA0, 2);
    idle(2);
    rd_reg(8'h03, "R10 overflow kept across frame");
    wr_reg(8'h02);
    rd_reg(8'h01, "R10 overflow cleared by bit1");
    rd_fifo(8'hA0, "R2 frame D byte0");
    rd_fifo(8'hA1, "R2 frame D byte1");
    rd_reg(8'h04, "R11 status empty only");

    // single-byte frame
    send_frame(8'h5A, 1);
    idle(2);
    chk(rx_empty == 1'b1, "R3 single byte frame empty", rx_empty, 1);
    chk(rx_irq == 1'b1, "R6 single byte frame irq", rx_irq, 1);
    rd_fifo(8'h5A, "R3 single byte read");
    rd_fifo(8'h00, "R4 after single byte");
    idle(2);

    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule